// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces operand addresses for indirect memory accesses. It keeps a small bank of pointer registers, step registers and buffer-length registers. On each access strobe, one pointer and one step are chosen. The pointer's current value is registered onto the address output. At the same clock edge the pointer is stepped by the signed step value and written back to the same pointer register.

When the length register tied to the pointer is nonzero, the stepped pointer is kept inside a circular buffer of that many words. The buffer's base is the pointer with its low bits cleared. The number of bits cleared is the smallest width whose power of two covers the length. A zero length gives plain linear stepping that wraps at the address width.

A build parameter can add a bit-reversed output path for the variant that serves only data memory. That path is useful for radix-2 transform reordering. The variant that may also address program memory leaves it out. Software loads and inspects all registers through one write port and one registered read port.

Top module: `circ_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, addr_vld is 0 and addr_out is 0. Every pointer, step and length register reads back as 0 after reset.
- R2: A write with wr_en=1 stores wr_data into the register chosen by wr_idx. The register class is chosen by wr_sel: 0 selects a pointer, 1 a step, 2 a length, and 3 writes nothing. rd_data shows the register chosen by rd_sel/rd_idx (same encoding) one clock after they are applied.
- R3: An access (acc_en=1) sets addr_vld=1 in the next cycle, and addr_out then holds the value the selected pointer had before the update.
- R4: With a length of 0, the pointer becomes pointer + step. The step is read as signed two's complement, and the sum wraps modulo 2^14.
- R5: With a nonzero length L, the base is the pointer with its low ceil(log2 L) bits cleared. A stepped value at or above base+L has L subtracted from it.
- R6: With a nonzero length L, a stepped value below the base has L added to it.
- R7: When the bit-reverse option is built in and acc_rev=1, addr_out is the updated pointer with bit k moved to bit 13-k. The stored pointer is not reversed, so the next plain access shows it unreversed.
- R8: When a pointer write and an access to the same pointer fall in the same cycle, the written value is stored and the post-modify result is dropped. The access still outputs the old pointer.
- R9: A cycle with acc_en=0 leaves addr_out unchanged, drives addr_vld to 0, and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register class for writes (0 pointer, 1 step, 2 length) |
| wr_idx | input | 2 | Register index for writes |
| wr_data | input | 14 | Write data |
| rd_sel | input | 2 | Register class for reads |
| rd_idx | input | 2 | Register index for reads |
| rd_data | output | 14 | Registered read data |
| acc_en | input | 1 | Access strobe |
| acc_ptr | input | 2 | Pointer chosen for the access |
| acc_mod | input | 2 | Step register chosen for the access |
| acc_rev | input | 1 | Request bit-reversed output (only when built in) |
| addr_out | output | 14 | Registered address |
| addr_vld | output | 1 | Address valid, one cycle after an access |

## Verification
Linear stepping is tried with positive and negative steps, and with a step that crosses the top of the 14-bit range. This separates sign-extension errors from carry errors. A 10-word buffer with an unaligned length is walked forward and backward across both of its ends. This shows whether the base mask and the two wrap directions are right. An aligned 8-word buffer near 0x2000 checks wrap in a buffer far from address zero. Directed cases cover reset contents, the same-cycle write/access collision, the bit-reversed output followed by a plain access, the ignored write class, and idle cycles.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    RK_PTR  = 2'd0,
    RK_STEP = 2'd1,
    RK_LEN  = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_t;
endpackage

// File: rtl/dag_regbank.sv
module dag_regbank #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  localparam int IW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic [IW-1:0] ptr_idx,
  input  logic [IW-1:0] step_idx,
  output logic [AW-1:0] ptr_val,
  output logic [AW-1:0] step_val,
  output logic [AW-1:0] len_val,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val
);
  import dag_pkg::*;

  logic [AW-1:0] ptr_q  [NPTR];
  logic [AW-1:0] step_q [NPTR];
  logic [AW-1:0] len_q  [NPTR];

  // pointer, step and length storage with write-over-update priority
  for (genvar g = 0; g < NPTR; g++) begin : g_slot
    logic ptr_wr, step_wr, len_wr, ptr_upd;
    assign ptr_wr  = wr_en && (wr_sel == RK_PTR)  && (wr_idx == IW'(g));
    assign step_wr = wr_en && (wr_sel == RK_STEP) && (wr_idx == IW'(g));
    assign len_wr  = wr_en && (wr_sel == RK_LEN)  && (wr_idx == IW'(g));
    assign ptr_upd = upd_en && (ptr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g]  <= '0;
        step_q[g] <= '0;
        len_q[g]  <= '0;
      end else begin
        if (ptr_wr)       ptr_q[g] <= wr_data;
        else if (ptr_upd) ptr_q[g] <= upd_val;
        if (step_wr)      step_q[g] <= wr_data;
        if (len_wr)       len_q[g]  <= wr_data;
      end
    end
  end

  assign ptr_val  = ptr_q[ptr_idx];
  assign len_val  = len_q[ptr_idx];
  assign step_val = step_q[step_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_sel)
        RK_PTR:  rd_data <= ptr_q[rd_idx];
        RK_STEP: rd_data <= step_q[rd_idx];
        RK_LEN:  rd_data <= len_q[rd_idx];
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dag_modulo.sv
module dag_modulo #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 2;

  logic [AW-1:0]        span_mask;
  logic [AW-1:0]        len_m1;
  logic signed [XW-1:0] sum_x, base_x, lim_x, fix_x;

  // mask covering every bit up to the top set bit of (len-1)
  always_comb begin
    len_m1    = len - AW'(1);
    span_mask = len_m1;
    for (int s = 1; s < AW; s++) begin
      span_mask = span_mask | (len_m1 >> s);
    end
  end

  always_comb begin
    sum_x  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
    base_x = $signed({2'b00, ptr & ~span_mask});
    lim_x  = base_x + $signed({2'b00, len});
    fix_x  = sum_x;
    if (len != '0) begin
      if (sum_x >= lim_x)      fix_x = sum_x - $signed({2'b00, len});
      else if (sum_x < base_x) fix_x = sum_x + $signed({2'b00, len});
    end
    nxt = fix_x[AW-1:0];
  end
endmodule

// File: rtl/dag_outstage.sv
module dag_outstage #(
  parameter int AW        = 14,
  parameter bit BITREV_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_rev,
  input  logic [AW-1:0] pre_addr,
  input  logic [AW-1:0] post_addr,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  logic [AW-1:0] rev_addr;
  logic          use_rev;

  assign use_rev = acc_rev && BITREV_EN;

  if (BITREV_EN) begin : g_rev
    for (genvar b = 0; b < AW; b++) begin : g_bit
      assign rev_addr[b] = post_addr[AW-1-b];
    end
  end else begin : g_norev
    assign rev_addr = pre_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_en;
      if (acc_en) addr_out <= use_rev ? rev_addr : pre_addr;
    end
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW        = 14,
  parameter int NPTR      = 4,
  parameter bit BITREV_EN = 1'b1,
  localparam int IW       = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic          acc_en,
  input  logic [IW-1:0] acc_ptr,
  input  logic [IW-1:0] acc_mod,
  input  logic          acc_rev,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  logic [AW-1:0] cur_ptr, cur_step, cur_len, nxt_ptr;

  dag_regbank #(.AW(AW), .NPTR(NPTR)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .ptr_idx(acc_ptr), .step_idx(acc_mod),
    .ptr_val(cur_ptr), .step_val(cur_step), .len_val(cur_len),
    .upd_en(acc_en), .upd_val(nxt_ptr)
  );

  dag_modulo #(.AW(AW)) u_mod (
    .ptr(cur_ptr), .step(cur_step), .len(cur_len), .nxt(nxt_ptr)
  );

  dag_outstage #(.AW(AW), .BITREV_EN(BITREV_EN)) u_out (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_rev(acc_rev),
    .pre_addr(cur_ptr), .post_addr(nxt_ptr),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en,
  input logic          acc_rev,
  input logic [AW-1:0] addr_out,
  input logic          addr_vld,
  input logic [AW-1:0] cur_ptr,
  input logic [AW-1:0] cur_step,
  input logic [AW-1:0] cur_len,
  input logic [AW-1:0] nxt_ptr
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!addr_vld && addr_out == '0)); // R1
  AST_VALID_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_vld); // R3
  AST_PRE_MODIFY_ADDR: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_rev) |=> (addr_out == $past(cur_ptr))); // R3
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_en && cur_len == '0) |-> (nxt_ptr == AW'(cur_ptr + cur_step))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (!addr_vld && $stable(addr_out))); // R9
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_rev(acc_rev),
  .addr_out(addr_out), .addr_vld(addr_vld),
  .cur_ptr(cur_ptr), .cur_step(cur_step), .cur_len(cur_len), .nxt_ptr(nxt_ptr)
);

// File: tb/circ_addr_gen_bench.sv
`timescale 1ns/1ps
module circ_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0, wr_idx = '0, rd_sel = '0, rd_idx = '0;
  logic [13:0] wr_data = '0;
  logic [13:0] rd_data, addr_out;
  logic        acc_en = 1'b0, acc_rev = 1'b0, addr_vld;
  logic [1:0]  acc_ptr = '0, acc_mod = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  circ_addr_gen u_circ_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod), .acc_rev(acc_rev),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  // {pointer, step, reverse, expected address}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 14'h0100},  // R4 forward step
    {2'd0, 2'd1, 1'b0, 14'h0103},  // R4 backward step
    {2'd1, 2'd2, 1'b0, 14'h0040},  // R5
    {2'd1, 2'd2, 1'b0, 14'h0045},  // R5 hits end, wraps to base
    {2'd1, 2'd2, 1'b0, 14'h0040},  // R5
    {2'd1, 2'd1, 1'b0, 14'h0045},  // R6
    {2'd1, 2'd1, 1'b0, 14'h0043},  // R6
    {2'd1, 2'd1, 1'b0, 14'h0041},  // R6 falls below base
    {2'd1, 2'd3, 1'b0, 14'h0049},  // R6 result, then R5 wrap
    {2'd1, 2'd0, 1'b0, 14'h0040},  // R5
    {2'd2, 2'd2, 1'b0, 14'h2005},  // R5 aligned buffer
    {2'd2, 2'd1, 1'b0, 14'h2002},  // R6
    {2'd2, 2'd1, 1'b0, 14'h2000},  // R6 below 0x2000
    {2'd3, 2'd3, 1'b0, 14'h3FFF},  // R4 top wraps to zero
    {2'd3, 2'd1, 1'b0, 14'h0000},  // R4 zero minus two
    {2'd0, 2'd0, 1'b1, 14'h0820},  // R7 reversed 0x0104
    {2'd0, 2'd0, 1'b0, 14'h0104}   // R7 stored value unreversed
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] idx, input logic [13:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] sel, input logic [1:0] idx,
                    input logic [13:0] exp);
    @(negedge clk);
    rd_sel = sel; rd_idx = idx;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic access(input string req, input logic [1:0] p, input logic [1:0] m,
                        input logic rv, input logic [13:0] exp);
    @(negedge clk);
    acc_en = 1'b1; acc_ptr = p; acc_mod = m; acc_rev = rv;
    @(negedge clk);
    acc_en = 1'b0; acc_rev = 1'b0;
    check(req, {13'd0, addr_vld}, 14'd1);
    check(req, addr_out, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vld", {13'd0, addr_vld}, 14'd0);
    check("R1 addr", addr_out, 14'd0);
    rst = 1'b0;
    check("R1 vld after release", {13'd0, addr_vld}, 14'd0);
    rd("R1 ptr", 2'd0, 2'd2, 14'd0);
    rd("R1 step", 2'd1, 2'd3, 14'd0);
    rd("R1 len", 2'd2, 2'd1, 14'd0);

    wr(2'd0, 2'd0, 14'h0100);
    wr(2'd0, 2'd1, 14'h0040);
    wr(2'd0, 2'd2, 14'h2005);
    wr(2'd0, 2'd3, 14'h3FFF);
    wr(2'd1, 2'd0, 14'd3);
    wr(2'd1, 2'd1, 14'h3FFE);
    wr(2'd1, 2'd2, 14'd5);
    wr(2'd1, 2'd3, 14'd1);
    wr(2'd2, 2'd1, 14'd10);
    wr(2'd2, 2'd2, 14'd8);
    wr(2'd3, 2'd1, 14'h1234);   // R2 class 3 must store nothing
    rd("R2 step1", 2'd1, 2'd1, 14'h3FFE);
    rd("R2 len1", 2'd2, 2'd1, 14'd10);
    rd("R2 ignored class", 2'd0, 2'd1, 14'h0040);

    for (int i = 0; i < NV; i++) begin
      access("R3 vector", VEC[i][18:17], VEC[i][16:15], VEC[i][14], VEC[i][13:0]);
    end
    rd("R5 ptr1 final", 2'd0, 2'd1, 14'h0043);
    rd("R6 ptr2 final", 2'd0, 2'd2, 14'h2006);
    rd("R4 ptr3 final", 2'd0, 2'd3, 14'h3FFE);
    rd("R7 ptr0 final", 2'd0, 2'd0, 14'h0107);

    // R8: write and access to pointer 0 in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 2'd0; wr_data = 14'h0200;
    acc_en = 1'b1; acc_ptr = 2'd0; acc_mod = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; acc_en = 1'b0;
    check("R8 old address out", addr_out, 14'h0107);
    rd("R8 write wins", 2'd0, 2'd0, 14'h0200);

    // R9: idle cycles hold the address and the pointer
    repeat (3) @(negedge clk);
    check("R9 vld low", {13'd0, addr_vld}, 14'd0);
    check("R9 addr held", addr_out, 14'h0107);
    rd("R9 ptr unchanged", 2'd0, 2'd0, 14'h0200);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule